// File: doc/BRIEF.md
# Receive Descriptor Ring Consumer

This block owns a small ring of receive descriptors and works through it from the head, one descriptor per poll. Each descriptor is a 32-bit status word. A stimulus model or receive engine fills it in through a write port, and the block reads it. Bit 31 marks who owns the descriptor. While bit 31 is set the receive side still holds it, and any poll reports nothing.

Once the receive side clears ownership, a poll with retrieve set classifies the descriptor into one of three outcomes:
- A good frame. The block reports the frame length with the four CRC octets removed, sets the ownership bit again to return the descriptor, and advances the head.
- A frame that spans several buffers. The block skips it and may flag it as oversize.
- A frame with a fatal error. The block asks for a reset and rewinds the head to entry 0.

A poll with retrieve clear is a peek: it only says whether the head descriptor is ready. Three counters keep running totals of good frames, oversize flags and fatal errors.

Top module: `rx_desc_consumer`

## Requirements
- R1: After reset, every descriptor holds 0x80000000 (owned by the receive side), the head index is 0, the three counters are 0, and resp_valid, pkt_ready, oversize_flag, reset_req and pkt_len are all 0.
- R2: A poll sampled on a clock edge produces a one-cycle resp_valid pulse on the next cycle, and there is no pulse without a poll. If status bit 31 of the head descriptor is set, the response has pkt_ready, oversize_flag and reset_req low, and the head index does not move.
- R3: A peek (poll_retrieve low) of a head descriptor with bit 31 clear reports pkt_ready high and pkt_len 0. It raises no other flag and changes neither the head, nor the counters, nor the descriptor, whatever the other status bits hold.
- R4: A retrieve of a descriptor whose status ANDed with 0x38008300 equals 0x00000300 is a good frame. It reports pkt_ready with pkt_len equal to status bits 26:16 minus 4, and good_count increments.
- R5: After a good frame, the descriptor is rewritten to 0x80000000 and the head advances by one. A later poll that reaches that entry again reports not ready until the entry is written anew.
- R6: A retrieve that is not good and whose status ANDed with 0x38000300 differs from 0x00000300 is a spanned frame. pkt_ready stays low and the descriptor is left as it is. oversize_flag is raised, and oversize_count increments, unless status bits 15:0 equal 0x7FFF. The head advances by one.
- R7: A retrieve whose status ANDed with 0x38000300 equals 0x00000300 but has bit 15 set is a fatal error. reset_req pulses with the response, the head index returns to 0, and fatal_count increments.
- R8: The head index steps modulo RING_DEPTH, from RING_DEPTH-1 back to 0, for any depth including ones that are not a power of two.
- R9: A write through the descriptor port replaces that entry's status on the same edge. If a write targets the entry being returned by a good-frame retrieve on the same edge, the return wins and the entry ends up at 0x80000000. The poll itself classifies the value held before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_wr_en | input | 1 | Write a descriptor status word |
| desc_wr_idx | input | IDX_W | Ring entry to write |
| desc_wr_data | input | 32 | Status word to store |
| poll_req | input | 1 | Examine the head descriptor this cycle |
| poll_retrieve | input | 1 | 1: consume the descriptor, 0: peek only |
| resp_valid | output | 1 | Response to the poll of the previous cycle |
| pkt_ready | output | 1 | Head descriptor held a frame (peek) or a good frame was taken |
| pkt_len | output | 11 | Good-frame length without CRC, else 0 |
| oversize_flag | output | 1 | Spanned frame that was not a continuation marker |
| reset_req | output | 1 | Fatal receive error; the head was rewound |
| head_idx | output | IDX_W | Current head entry |
| good_count | output | CNT_W | Number of good frames taken, wrapping |
| oversize_count | output | CNT_W | Number of oversize flags raised, wrapping |
| fatal_count | output | CNT_W | Number of fatal errors, wrapping |

## Verification
The bench builds the block with RING_DEPTH = 3 and CNT_W = 8. A depth of three means the head wraps from entry 2 to entry 0, so a consumer that wraps by truncating the index bits would visit an entry that does not exist, and the bench would see it. Three entries also let one sequence do all of the following: return a descriptor, fill the two others, and come back to the returned one to see that it is owned again. That same loop confirms that a release overrides a write made in the same cycle.

// File: rtl/rdc_pkg.sv
// Package: shared constants and types for the receive descriptor consumer.
// Assumes 32-bit status words; the length field sits in bits 26:16.
package rdc_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned LEN_W  = 11;

    // Ownership bit value written back when a descriptor is returned
    localparam logic [WORD_W-1:0] OWN_WORD   = 32'h8000_0000;
    // Frame-boundary pattern plus error bit: must equal FRAME_CMP for a good frame
    localparam logic [WORD_W-1:0] GOOD_MASK  = 32'h3800_8300;
    // Frame-boundary pattern alone: a mismatch means the frame spans buffers
    localparam logic [WORD_W-1:0] FRAME_MASK = 32'h3800_0300;
    localparam logic [WORD_W-1:0] FRAME_CMP  = 32'h0000_0300;
    // Low half-word of a quiet continuation buffer
    localparam logic [15:0]       CONT_MARK  = 16'h7FFF;
    // CRC octets removed from the reported length
    localparam logic [LEN_W-1:0]  CRC_BYTES  = 11'd4;

    typedef enum logic [1:0] {
        CLS_BUSY  = 2'd0,
        CLS_GOOD  = 2'd1,
        CLS_SPAN  = 2'd2,
        CLS_FATAL = 2'd3
    } cls_kind_e;

    typedef struct packed {
        cls_kind_e        kind;
        logic             oversize;
        logic [LEN_W-1:0] len;
    } cls_t;

endpackage

// File: rtl/rdc_desc_store.sv
// Module: holds the status word of every ring entry in flops.
// A write from the stimulus side and a release from the consumer may hit
// the same entry on one edge; the release takes priority. The head entry
// is presented combinationally. Assumes head_idx < DEPTH.
module rdc_desc_store
    import rdc_pkg::*;
#(
    parameter int unsigned DEPTH = 2,
    parameter int unsigned IDX_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rel_en,
    input  logic [IDX_W-1:0]  head_idx,
    output logic [WORD_W-1:0] head_status
);

    logic [WORD_W-1:0] entry_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);

        // Update one entry: reset to owned, release wins over a write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_q[g] <= OWN_WORD;
            end else if (rel_en && (head_idx == MY_IDX)) begin
                entry_q[g] <= OWN_WORD;
            end else if (wr_en && (wr_idx == MY_IDX)) begin
                entry_q[g] <= wr_data;
            end
        end
    end

    // Select the status word at the head
    always_comb begin
        head_status = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (head_idx == IDX_W'(i)) begin
                head_status = entry_q[i];
            end
        end
    end

endmodule

// File: rtl/rdc_classify.sv
// Module: decodes one status word into busy / good / spanned / fatal.
// Purely combinational; the length is only meaningful for a good frame.
module rdc_classify
    import rdc_pkg::*;
(
    input  logic [WORD_W-1:0] status,
    output cls_t              cls
);

    logic frame_whole;
    logic good_hit;

    // Boundary pattern and good-frame pattern matches
    always_comb begin
        frame_whole = ((status & FRAME_MASK) == FRAME_CMP);
        good_hit    = ((status & GOOD_MASK) == FRAME_CMP);
    end

    // Priority decode: ownership, then good, then spanned, else fatal
    always_comb begin
        cls.kind     = CLS_BUSY;
        cls.oversize = 1'b0;
        cls.len      = '0;
        if (status[WORD_W-1]) begin
            cls.kind = CLS_BUSY;
        end else if (good_hit) begin
            cls.kind = CLS_GOOD;
            cls.len  = status[26:16] - CRC_BYTES;
        end else if (!frame_whole) begin
            cls.kind     = CLS_SPAN;
            cls.oversize = (status[15:0] != CONT_MARK);
        end else begin
            cls.kind = CLS_FATAL;
        end
    end

endmodule

// File: rtl/rdc_head_ctrl.sv
// Module: acts on a poll: moves the head, returns good descriptors,
// registers the response and keeps the three event counters.
// Assumes cls describes the descriptor at head_idx in the same cycle.
module rdc_head_ctrl
    import rdc_pkg::*;
#(
    parameter int unsigned DEPTH = 2,
    parameter int unsigned IDX_W = 1,
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             poll_req,
    input  logic             poll_retrieve,
    input  cls_t             cls,
    output logic [IDX_W-1:0] head_idx,
    output logic             rel_en,
    output logic             resp_valid,
    output logic             rsp_ready,
    output logic [LEN_W-1:0] rsp_len,
    output logic             rsp_oversize,
    output logic             rsp_fatal,
    output logic [CNT_W-1:0] good_cnt,
    output logic [CNT_W-1:0] over_cnt,
    output logic [CNT_W-1:0] fatal_cnt
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
    localparam int unsigned      N_CNT    = 3;

    logic             take;
    logic             is_good;
    logic             is_span;
    logic             is_fatal;
    logic             peek_hit;
    logic [IDX_W-1:0] head_q;
    logic [IDX_W-1:0] head_nxt;
    logic [N_CNT-1:0] cnt_inc;
    logic [CNT_W-1:0] cnt_q [N_CNT];

    // Decode what this poll does to the ring
    always_comb begin
        take     = poll_req && poll_retrieve;
        is_good  = take && (cls.kind == CLS_GOOD);
        is_span  = take && (cls.kind == CLS_SPAN);
        is_fatal = take && (cls.kind == CLS_FATAL);
        peek_hit = poll_req && !poll_retrieve && (cls.kind != CLS_BUSY);
        rel_en   = is_good;
    end

    // Next head: rewind on fatal, step with wrap on good or spanned
    always_comb begin
        head_nxt = head_q;
        if (is_fatal) begin
            head_nxt = '0;
        end else if (is_good || is_span) begin
            head_nxt = (head_q == LAST_IDX) ? '0 : head_q + IDX_W'(1);
        end
    end

    // Head index register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
        end else begin
            head_q <= head_nxt;
        end
    end

    // Registered poll response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid   <= 1'b0;
            rsp_ready    <= 1'b0;
            rsp_len      <= '0;
            rsp_oversize <= 1'b0;
            rsp_fatal    <= 1'b0;
        end else begin
            resp_valid   <= poll_req;
            rsp_ready    <= peek_hit || is_good;
            rsp_len      <= is_good ? cls.len : '0;
            rsp_oversize <= is_span && cls.oversize;
            rsp_fatal    <= is_fatal;
        end
    end

    assign cnt_inc = {is_fatal, is_span && cls.oversize, is_good};

    for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
        // One wrapping event counter
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q[k] <= '0;
            end else if (cnt_inc[k]) begin
                cnt_q[k] <= cnt_q[k] + CNT_W'(1);
            end
        end
    end

    assign head_idx  = head_q;
    assign good_cnt  = cnt_q[0];
    assign over_cnt  = cnt_q[1];
    assign fatal_cnt = cnt_q[2];

endmodule

// File: rtl/rx_desc_consumer.sv
// Module: top of the receive descriptor ring consumer.
// Connects the descriptor store, the status classifier and the head
// controller. Assumes one poll per cycle at most and RING_DEPTH >= 1.
module rx_desc_consumer
    import rdc_pkg::*;
#(
    parameter int unsigned RING_DEPTH = 2,
    parameter int unsigned CNT_W      = 16,
    localparam int unsigned IDX_W     = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             desc_wr_en,
    input  logic [IDX_W-1:0] desc_wr_idx,
    input  logic [31:0]      desc_wr_data,
    input  logic             poll_req,
    input  logic             poll_retrieve,
    output logic             resp_valid,
    output logic             pkt_ready,
    output logic [10:0]      pkt_len,
    output logic             oversize_flag,
    output logic             reset_req,
    output logic [IDX_W-1:0] head_idx,
    output logic [CNT_W-1:0] good_count,
    output logic [CNT_W-1:0] oversize_count,
    output logic [CNT_W-1:0] fatal_count
);

    logic [WORD_W-1:0] head_status;
    logic              rel_en;
    cls_t              cls;

    rdc_desc_store #(
        .DEPTH (RING_DEPTH),
        .IDX_W (IDX_W)
    ) i_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (desc_wr_en),
        .wr_idx      (desc_wr_idx),
        .wr_data     (desc_wr_data),
        .rel_en      (rel_en),
        .head_idx    (head_idx),
        .head_status (head_status)
    );

    rdc_classify i_classify (
        .status (head_status),
        .cls    (cls)
    );

    rdc_head_ctrl #(
        .DEPTH (RING_DEPTH),
        .IDX_W (IDX_W),
        .CNT_W (CNT_W)
    ) i_head (
        .clk           (clk),
        .rst_n         (rst_n),
        .poll_req      (poll_req),
        .poll_retrieve (poll_retrieve),
        .cls           (cls),
        .head_idx      (head_idx),
        .rel_en        (rel_en),
        .resp_valid    (resp_valid),
        .rsp_ready     (pkt_ready),
        .rsp_len       (pkt_len),
        .rsp_oversize  (oversize_flag),
        .rsp_fatal     (reset_req),
        .good_cnt      (good_count),
        .over_cnt      (oversize_count),
        .fatal_cnt     (fatal_count)
    );

endmodule

// File: rtl/rx_desc_consumer_checker.sv
// Module: property checker for rx_desc_consumer, attached with bind.
// Watches the port-level response, head and counters over time.
module rx_desc_consumer_checker #(
    parameter int unsigned RING_DEPTH = 2,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned IDX_W      = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             poll_req,
    input logic             poll_retrieve,
    input logic             resp_valid,
    input logic             pkt_ready,
    input logic [10:0]      pkt_len,
    input logic             oversize_flag,
    input logic             reset_req,
    input logic [IDX_W-1:0] head_idx,
    input logic [CNT_W-1:0] good_count,
    input logic [CNT_W-1:0] fatal_count
);

    // R2: a response pulse follows exactly the cycles that carried a poll
    assert_resp_follows_poll_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (resp_valid == $past(poll_req)));

    // R2: no result flag without a response
    assert_flags_need_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_ready || oversize_flag || reset_req) |-> resp_valid);

    // R2: the head only moves on an edge that also produced a response
    assert_head_moves_on_poll_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(head_idx) |-> resp_valid);

    // R3: a peek never raises the oversize or reset flags
    assert_peek_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !$past(poll_retrieve)) |-> (!oversize_flag && !reset_req));

    // R4: a nonzero length comes only with a ready frame
    assert_len_needs_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_len != 11'd0) |-> pkt_ready);

    // R4: the good counter moves only with a ready response
    assert_good_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (good_count != $past(good_count)) |-> pkt_ready);

    // R6: the three outcomes never coincide
    assert_outcome_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pkt_ready, oversize_flag, reset_req}));

    // R7: a reset request leaves the head at entry 0 with a counted event
    assert_fatal_rewinds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> (head_idx == '0));

    assert_fatal_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fatal_count != $past(fatal_count)) |-> reset_req);

    // R8: the head never leaves the ring
    assert_head_in_ring_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(head_idx) < RING_DEPTH));

endmodule

bind rx_desc_consumer rx_desc_consumer_checker #(
    .RING_DEPTH (RING_DEPTH),
    .CNT_W      (CNT_W),
    .IDX_W      (IDX_W)
) i_rdc_chk (.*);

// File: tb/test_rx_desc_consumer.sv
`timescale 1ns/1ps
// Bench: scoreboard for rx_desc_consumer. The driver task predicts each
// poll response from a model of the ring and queues it; the monitor pops
// and compares on every response pulse.
module test_rx_desc_consumer;

    localparam int unsigned DEPTH   = 3;
    localparam int unsigned CNT_W   = 8;
    localparam int unsigned IDX_W   = 2;
    localparam int unsigned MAX_CYC = 20000;

    typedef struct packed {
        logic        ready;
        logic [10:0] len;
        logic        over;
        logic        fatal;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             desc_wr_en = 1'b0;
    logic [IDX_W-1:0] desc_wr_idx = '0;
    logic [31:0]      desc_wr_data = '0;
    logic             poll_req = 1'b0;
    logic             poll_retrieve = 1'b0;
    logic             resp_valid;
    logic             pkt_ready;
    logic [10:0]      pkt_len;
    logic             oversize_flag;
    logic             reset_req;
    logic [IDX_W-1:0] head_idx;
    logic [CNT_W-1:0] good_count;
    logic [CNT_W-1:0] oversize_count;
    logic [CNT_W-1:0] fatal_count;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    exp_t  exp_q[$];
    string tag_q[$];

    logic [31:0] m_desc [DEPTH];
    int          m_head  = 0;
    int          m_good  = 0;
    int          m_over  = 0;
    int          m_fatal = 0;

    always #2.5 clk = ~clk;

    rx_desc_consumer #(
        .RING_DEPTH (DEPTH),
        .CNT_W      (CNT_W)
    ) i_rx_desc_consumer (
        .clk            (clk),
        .rst_n          (rst_n),
        .desc_wr_en     (desc_wr_en),
        .desc_wr_idx    (desc_wr_idx),
        .desc_wr_data   (desc_wr_data),
        .poll_req       (poll_req),
        .poll_retrieve  (poll_retrieve),
        .resp_valid     (resp_valid),
        .pkt_ready      (pkt_ready),
        .pkt_len        (pkt_len),
        .oversize_flag  (oversize_flag),
        .reset_req      (reset_req),
        .head_idx       (head_idx),
        .good_count     (good_count),
        .oversize_count (oversize_count),
        .fatal_count    (fatal_count)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One cycle of stimulus: optional poll and optional descriptor write
    task automatic step(input bit do_poll, input bit retr, input bit do_wr,
                        input int widx, input logic [31:0] wdata, input string tag);
        exp_t        e;
        logic [31:0] s;
        int          h;
        bit          rel;
        e   = '0;
        rel = 1'b0;
        h   = m_head;
        s   = m_desc[h];
        if (do_poll && !s[31]) begin
            if (!retr) begin
                e.ready = 1'b1;
            end else if ((s & 32'h3800_8300) == 32'h0000_0300) begin
                e.ready = 1'b1;
                e.len   = s[26:16] - 11'd4;
                rel     = 1'b1;
                m_good++;
                m_head  = (h + 1) % DEPTH;
            end else if ((s & 32'h3800_0300) != 32'h0000_0300) begin
                e.over = (s[15:0] != 16'h7FFF);
                if (e.over) m_over++;
                m_head = (h + 1) % DEPTH;
            end else begin
                e.fatal = 1'b1;
                m_fatal++;
                m_head  = 0;
            end
        end
        if (do_poll) begin
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
        if (do_wr) m_desc[widx] = wdata;
        if (rel) m_desc[h] = 32'h8000_0000;
        poll_req      = do_poll;
        poll_retrieve = retr;
        desc_wr_en    = do_wr;
        desc_wr_idx   = widx[IDX_W-1:0];
        desc_wr_data  = wdata;
        @(negedge clk);
        poll_req      = 1'b0;
        poll_retrieve = 1'b0;
        desc_wr_en    = 1'b0;
    endtask

    task automatic wr(input int widx, input logic [31:0] wdata, input string tag);
        step(1'b0, 1'b0, 1'b1, widx, wdata, tag);
    endtask

    task automatic poll(input bit retr, input string tag);
        step(1'b1, retr, 1'b0, 0, 32'h0, tag);
    endtask

    task automatic check_state(input string tag);
        check(head_idx == IDX_W'(m_head), tag, "head_idx", head_idx, m_head);
        check(good_count == CNT_W'(m_good), tag, "good_count", good_count, m_good);
        check(oversize_count == CNT_W'(m_over), tag, "oversize_count", oversize_count, m_over);
        check(fatal_count == CNT_W'(m_fatal), tag, "fatal_count", fatal_count, m_fatal);
    endtask

    // Monitor: compare each response pulse against the queued prediction
    always @(negedge clk) begin
        if (rst_n && resp_valid && !done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "unexpected response", 1, 0);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({pkt_ready, pkt_len, oversize_flag, reset_req} == e, t,
                      "{ready,len,over,fatal}",
                      {pkt_ready, pkt_len, oversize_flag, reset_req}, e);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", MAX_CYC, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_desc[i] = 32'h8000_0000;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state at the ports
        check(!resp_valid && !pkt_ready && !oversize_flag && !reset_req, "R1",
              "flags", {resp_valid, pkt_ready, oversize_flag, reset_req}, 0);
        check(pkt_len == 11'd0, "R1", "pkt_len", pkt_len, 0);
        check_state("R1");

        // R1 R2: owned descriptors report nothing, head stays
        poll(1'b1, "R2");
        poll(1'b0, "R2");
        check_state("R2");

        // R3: peek a good frame, nothing consumed
        wr(0, 32'h0044_0300, "R9");
        poll(1'b0, "R3");
        check_state("R3");

        // R4: retrieve the good frame, length 68-4
        poll(1'b1, "R4");
        check_state("R4");

        // R6: spanned with oversize, then quiet continuation wrapping head (R8)
        wr(1, 32'h0000_0100, "R9");
        wr(2, 32'h0800_7FFF, "R9");
        poll(1'b1, "R6");
        check_state("R6");
        poll(1'b1, "R8");
        check_state("R8");

        // R5: entry 0 was returned, so it is owned again
        poll(1'b1, "R5");
        check_state("R5");

        // R4: minimum length field 4 gives length 0 but ready
        wr(0, 32'h0004_0300, "R9");
        poll(1'b1, "R4");
        check_state("R4");

        // R3: peek at a fatal descriptor raises no reset
        wr(1, 32'h0010_8300, "R9");
        poll(1'b0, "R3");
        check_state("R3");

        // R7: fatal retrieve rewinds head to 0
        poll(1'b1, "R7");
        check_state("R7");

        // R9: release beats a same-cycle write to the returned entry
        wr(0, 32'h0014_0300, "R9");
        step(1'b1, 1'b1, 1'b1, 0, 32'h0020_0300, "R9");
        check_state("R9");
        // R9: write to another entry lands during a poll; back-to-back polls
        wr(1, 32'h0040_0300, "R9");
        step(1'b1, 1'b1, 1'b1, 2, 32'h0048_0300, "R9");
        poll(1'b1, "R9");
        poll(1'b1, "R9");
        check_state("R9");

        // R6: reserved boundary bit and end-only pattern count as spanned
        wr(0, 32'h1000_0300, "R9");
        poll(1'b1, "R6");
        wr(1, 32'h0000_0200, "R9");
        poll(1'b1, "R6");
        check_state("R6");

        // R4 R8: full-size frame in the last entry, head wraps to 0
        wr(2, 32'h05EE_0300, "R9");
        poll(1'b1, "R4");
        check_state("R8");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2", "missing responses", exp_q.size(), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule